// File: doc/BRIEF.md
# Alpha-to-Coverage Sample Mask Generator

This block turns the alpha of a pixel's first colour output into a per-sample coverage reduction. For each pixel it takes the sample mask produced by rasterization, an 8-bit unsigned fixed-point alpha (0 means fully transparent, the all-ones code means fully opaque), and the multisample mode written as the base-2 logarithm of the sample count. Each active mask slot has a fixed alpha threshold, and these thresholds are interleaved across the slots. A slot keeps its rasterizer bit only when alpha reaches that slot's threshold. A pixel that is left with no covered slot is flagged for discard, so the per-sample depth/stencil stage that follows never sees it.

The alpha must be the raw shader value. Any power-of-two exponent scaling of the colour is applied downstream of this block. The operation is switched off by a pipeline-state enable, or when the shader does not produce colour target 0 (a depth-only shader, for example). In that case the rasterizer mask is forwarded untouched and no discard is raised. Pixels enter and leave over a valid/ready handshake through a single output register.

Top module: `a2c_mask_gen`

## Requirements
- R1: When `feat_en` is 0, `out_mask` equals the incoming `in_cov` and `out_kill` is 0.
- R2: When `color0_live` is 0, `out_mask` equals `in_cov` and `out_kill` is 0, whatever the alpha.
- R3: With the operation active and `sample_log2` = 2 (4 samples), mask slots 0, 1, 2 and 3 pass when alpha >= 159, 96, 32 and 223 respectively.
- R4: With `sample_log2` = 1 (2 samples, slot 0 = top-left, slot 1 = bottom-right), slot 0 passes when alpha >= 191 and slot 1 when alpha >= 64. Slots 2 and 3 are always 0 in the output.
- R5: With `sample_log2` = 0 (1 sample), slot 0 passes when alpha >= 128. Slots 1 to 3 are always 0 in the output.
- R6: The code `sample_log2` = 3 behaves exactly like 4-sample mode.
- R7: While the operation is active, `out_mask` is the bitwise AND of the threshold pass vector with `in_cov`, so no bit is set that was clear in `in_cov`.
- R8: While the operation is active, `out_kill` is 1 exactly when `out_mask` is all zero.
- R9: Alpha 255 passes every slot of the current mode, and alpha 0 passes none.
- R10: A pixel accepted on a rising edge appears on `out_valid`/`out_mask`/`out_kill` immediately after that same edge. After reset, `out_valid` is 0.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output holds stable and `in_ready` is 0. Otherwise `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel can be taken this cycle |
| in_cov | input | 4 | Rasterizer coverage, one bit per mask slot |
| in_alpha | input | 8 | Unbiased alpha of colour target 0, unorm |
| sample_log2 | input | 2 | log2 of the sample count (3 treated as 2) |
| feat_en | input | 1 | Alpha-to-coverage state enable |
| color0_live | input | 1 | Shader writes colour target 0 and is not depth-only |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_mask | output | 4 | Reduced per-sample coverage |
| out_kill | output | 1 | Pixel discarded before depth/stencil |

## Verification
All results come from one register stage. A pixel driven at a falling edge is taken at the next rising edge, and its mask and kill flag can be read at the falling edge that follows. This is where every directed task samples. The one-cycle result also means `out_valid` must drop again at the falling edge after that, when no further pixel is offered. The back-pressure task keeps `out_ready` low for a whole cycle and checks at that falling edge that the held result and `in_ready` are unchanged. It then releases the output and expects the queued pixel exactly one edge later.

// File: rtl/a2c_pkg.sv
// Shared constants and helpers for the alpha-to-coverage mask generator.
// Assumes at most four coverage slots; thresholds are expressed in eighths.
package a2c_pkg;
    localparam int unsigned N_SLOTS = 4;

    typedef enum logic [1:0] {
        MODE_1X  = 2'd0,
        MODE_2X  = 2'd1,
        MODE_4X  = 2'd2,
        MODE_RSV = 2'd3
    } smode_e;

    // Round k/8 of the full-scale unorm code to the nearest integer.
    function automatic int unsigned eighth_code(int unsigned k, int unsigned w);
        return (k * ((1 << w) - 1) + 4) >> 3;
    endfunction
endpackage

// File: rtl/a2c_thresh_sel.sv
// Selects the per-slot alpha thresholds and the slot-enable vector for the
// current multisample mode. Purely combinational; reserved mode maps to 4x.
module a2c_thresh_sel
    import a2c_pkg::*;
#(
    parameter int unsigned ALPHA_W = 8
) (
    input  logic [1:0]                           mode,
    output logic [N_SLOTS-1:0][ALPHA_W-1:0]      thr,
    output logic [N_SLOTS-1:0]                   slot_en
);
    localparam logic [ALPHA_W-1:0] T_1_8 = ALPHA_W'(eighth_code(1, ALPHA_W));
    localparam logic [ALPHA_W-1:0] T_2_8 = ALPHA_W'(eighth_code(2, ALPHA_W));
    localparam logic [ALPHA_W-1:0] T_3_8 = ALPHA_W'(eighth_code(3, ALPHA_W));
    localparam logic [ALPHA_W-1:0] T_4_8 = ALPHA_W'(eighth_code(4, ALPHA_W));
    localparam logic [ALPHA_W-1:0] T_5_8 = ALPHA_W'(eighth_code(5, ALPHA_W));
    localparam logic [ALPHA_W-1:0] T_6_8 = ALPHA_W'(eighth_code(6, ALPHA_W));
    localparam logic [ALPHA_W-1:0] T_7_8 = ALPHA_W'(eighth_code(7, ALPHA_W));

    // Mode decode to interleaved threshold set.
    always_comb begin
        thr     = '0;
        slot_en = '0;
        case (smode_e'(mode))
            MODE_1X: begin
                thr[0]  = T_4_8;
                slot_en = 4'b0001;
            end
            MODE_2X: begin
                thr[0]  = T_6_8;
                thr[1]  = T_2_8;
                slot_en = 4'b0011;
            end
            default: begin
                thr[0]  = T_5_8;
                thr[1]  = T_3_8;
                thr[2]  = T_1_8;
                thr[3]  = T_7_8;
                slot_en = 4'b1111;
            end
        endcase
    end
endmodule

// File: rtl/a2c_cmp.sv
// Per-slot alpha comparison: a slot passes when it is enabled for the mode
// and alpha is at or above its threshold. Combinational.
module a2c_cmp
    import a2c_pkg::*;
#(
    parameter int unsigned ALPHA_W = 8
) (
    input  logic [ALPHA_W-1:0]                   alpha,
    input  logic [N_SLOTS-1:0][ALPHA_W-1:0]      thr,
    input  logic [N_SLOTS-1:0]                   slot_en,
    output logic [N_SLOTS-1:0]                   pass
);
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        // Threshold test for one slot.
        always_comb pass[s] = slot_en[s] && (alpha >= thr[s]);
    end
endmodule

// File: rtl/a2c_out_reg.sv
// One-entry output register with valid/ready handshake. Accepts a new word
// whenever empty or being drained in the same cycle; holds under stall.
module a2c_out_reg #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    // Ready when nothing is held or the held word leaves now.
    always_comb in_ready = !out_valid || out_ready;

    // Valid flag tracking.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (in_ready) out_valid <= in_valid;
    end

    // Data capture on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)                    out_data <= '0;
        else if (in_valid && in_ready) out_data <= in_data;
    end
endmodule

// File: rtl/a2c_mask_gen.sv
// Alpha-to-coverage mask generator. Reduces rasterizer coverage by
// comparing unbiased colour-0 alpha against mode-dependent per-slot
// thresholds and flags pixels left with no coverage. Assumes the coverage
// input is already in slot order for the selected mode.
module a2c_mask_gen
    import a2c_pkg::*;
#(
    parameter int unsigned ALPHA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [3:0]         in_cov,
    input  logic [ALPHA_W-1:0] in_alpha,
    input  logic [1:0]         sample_log2,
    input  logic               feat_en,
    input  logic               color0_live,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [3:0]         out_mask,
    output logic               out_kill
);
    localparam int unsigned DW = N_SLOTS + 1;

    logic [N_SLOTS-1:0][ALPHA_W-1:0] thr;
    logic [N_SLOTS-1:0]              slot_en;
    logic [N_SLOTS-1:0]              pass;
    logic                            active;
    logic [N_SLOTS-1:0]              nxt_mask;
    logic                            nxt_kill;
    logic [DW-1:0]                   q_data;

    a2c_thresh_sel #(.ALPHA_W(ALPHA_W)) u_sel (
        .mode    (sample_log2),
        .thr     (thr),
        .slot_en (slot_en)
    );

    a2c_cmp #(.ALPHA_W(ALPHA_W)) u_cmp (
        .alpha   (in_alpha),
        .thr     (thr),
        .slot_en (slot_en),
        .pass    (pass)
    );

    // Apply the reduction only when enabled and colour 0 is produced.
    always_comb begin
        active   = feat_en && color0_live;
        nxt_mask = active ? (pass & in_cov) : in_cov;
        nxt_kill = active && ((pass & in_cov) == '0);
    end

    a2c_out_reg #(.W(DW)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   ({nxt_kill, nxt_mask}),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (q_data)
    );

    // Split the registered word.
    always_comb begin
        out_mask = q_data[N_SLOTS-1:0];
        out_kill = q_data[DW-1];
    end
endmodule

// File: rtl/a2c_mask_gen_chk.sv
// Property checker for a2c_mask_gen, attached by bind below.
module a2c_mask_gen_chk #(
    parameter int unsigned ALPHA_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [3:0]         in_cov,
    input logic [ALPHA_W-1:0] in_alpha,
    input logic [1:0]         sample_log2,
    input logic               feat_en,
    input logic               color0_live,
    input logic               out_valid,
    input logic               out_ready,
    input logic [3:0]         out_mask,
    input logic               out_kill
);
    logic acc;
    logic on;
    always_comb acc = in_valid && in_ready;
    always_comb on  = feat_en && color0_live && (in_alpha == in_alpha);

    a_r1_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !on |=> out_mask == $past(in_cov) && !out_kill);
    a_r7_subset: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_mask & ~$past(in_cov)) == 4'b0000);
    a_r4_two_slots: assert property (@(posedge clk) disable iff (!rst_n)
        acc && on && sample_log2 == 2'd1 |=> out_mask[3:2] == 2'b00);
    a_r5_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        acc && on && sample_log2 == 2'd0 |=> out_mask[3:1] == 3'b000);
    a_r8_kill: assert property (@(posedge clk) disable iff (!rst_n)
        acc && on |=> out_kill == (out_mask == 4'b0000));
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_mask) && $stable(out_kill));
    a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready));
endmodule

bind a2c_mask_gen a2c_mask_gen_chk #(.ALPHA_W(ALPHA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cov(in_cov), .in_alpha(in_alpha), .sample_log2(sample_log2),
    .feat_en(feat_en), .color0_live(color0_live), .out_valid(out_valid),
    .out_ready(out_ready), .out_mask(out_mask), .out_kill(out_kill)
);

// File: tb/sim_a2c_mask_gen.sv
module sim_a2c_mask_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] in_cov = '0;
    logic [7:0] in_alpha = '0;
    logic [1:0] sample_log2 = '0;
    logic       feat_en = 1'b0;
    logic       color0_live = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [3:0] out_mask;
    logic       out_kill;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    a2c_mask_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cov(in_cov), .in_alpha(in_alpha), .sample_log2(sample_log2),
        .feat_en(feat_en), .color0_live(color0_live), .out_valid(out_valid),
        .out_ready(out_ready), .out_mask(out_mask), .out_kill(out_kill)
    );

    // Expected result from the requirements' thresholds.
    function automatic logic [4:0] model(logic [3:0] cov, logic [7:0] a,
                                         logic [1:0] m, logic en, logic live);
        logic [3:0] p;
        logic [3:0] r;
        if (!(en && live)) return {1'b0, cov};
        case (m)
            2'd0: p = {3'b000, a >= 8'd128};
            2'd1: p = {2'b00, a >= 8'd64, a >= 8'd191};
            default: p = {a >= 8'd223, a >= 8'd32, a >= 8'd96, a >= 8'd159};
        endcase
        r = p & cov;
        return {r == 4'b0000, r};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one pixel, let it be taken, check result one edge later.
    task automatic send(string req, logic [3:0] cov, logic [7:0] a,
                        logic [1:0] m, logic en, logic live);
        logic [4:0] e;
        e = model(cov, a, m, en, live);
        @(negedge clk);
        in_valid = 1'b1; in_cov = cov; in_alpha = a;
        sample_log2 = m; feat_en = en; color0_live = live;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {out_valid, out_kill, out_mask}, {1'b1, e});
    endtask

    task automatic t_reset();
        check("R10 reset", {31'd0, out_valid}, 32'd0);
        check("R11 reset ready", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_bypass();
        send("R1", 4'b1011, 8'd0, 2'd2, 1'b0, 1'b1);
        send("R1", 4'b0000, 8'd255, 2'd0, 1'b0, 1'b1);
        send("R2", 4'b1111, 8'd10, 2'd2, 1'b1, 1'b0);
        send("R2", 4'b0110, 8'd0, 2'd1, 1'b1, 1'b0);
    endtask

    task automatic t_four();
        send("R3 a159", 4'b1111, 8'd159, 2'd2, 1'b1, 1'b1);
        send("R3 a158", 4'b1111, 8'd158, 2'd2, 1'b1, 1'b1);
        send("R3 a96", 4'b1111, 8'd96, 2'd2, 1'b1, 1'b1);
        send("R3 a31", 4'b1111, 8'd31, 2'd2, 1'b1, 1'b1);
        send("R3 a223", 4'b1111, 8'd223, 2'd2, 1'b1, 1'b1);
        send("R3 a222", 4'b1111, 8'd222, 2'd2, 1'b1, 1'b1);
    endtask

    task automatic t_two();
        send("R4 a191", 4'b1111, 8'd191, 2'd1, 1'b1, 1'b1);
        send("R4 a190", 4'b1111, 8'd190, 2'd1, 1'b1, 1'b1);
        send("R4 a64", 4'b1111, 8'd64, 2'd1, 1'b1, 1'b1);
        send("R4 a63", 4'b1111, 8'd63, 2'd1, 1'b1, 1'b1);
    endtask

    task automatic t_one();
        send("R5 a128", 4'b1111, 8'd128, 2'd0, 1'b1, 1'b1);
        send("R5 a127", 4'b1111, 8'd127, 2'd0, 1'b1, 1'b1);
    endtask

    task automatic t_reserved();
        send("R6 a100", 4'b1111, 8'd100, 2'd3, 1'b1, 1'b1);
        send("R6 a224", 4'b1111, 8'd224, 2'd3, 1'b1, 1'b1);
    endtask

    task automatic t_and_kill();
        send("R7", 4'b0101, 8'd200, 2'd2, 1'b1, 1'b1);
        send("R7", 4'b1010, 8'd100, 2'd2, 1'b1, 1'b1);
        send("R8 kill", 4'b1010, 8'd40, 2'd2, 1'b1, 1'b1);
        send("R8 kill", 4'b0000, 8'd255, 2'd2, 1'b1, 1'b1);
        send("R8 nokill", 4'b0001, 8'd200, 2'd1, 1'b1, 1'b1);
    endtask

    task automatic t_extremes();
        for (int m = 0; m < 4; m++) begin
            send("R9 a255", 4'b1111, 8'd255, 2'(m), 1'b1, 1'b1);
            send("R9 a0", 4'b1111, 8'd0, 2'(m), 1'b1, 1'b1);
        end
    endtask

    task automatic t_latency();
        send("R10 first", 4'b0011, 8'd0, 2'd1, 1'b0, 1'b1);
        @(negedge clk);
        check("R10 drop", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_stall();
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_cov = 4'b1111; in_alpha = 8'd100;
        sample_log2 = 2'd2; feat_en = 1'b1; color0_live = 1'b1;
        @(negedge clk);
        check("R11 first", {27'd0, out_valid, out_kill, out_mask}, {27'd0, 1'b1, 1'b0, 4'b0110});
        in_cov = 4'b1001; in_alpha = 8'd10;
        @(negedge clk);
        check("R11 hold", {27'd0, out_valid, out_kill, out_mask}, {27'd0, 1'b1, 1'b0, 4'b0110});
        check("R11 ready low", {31'd0, in_ready}, 32'd0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 next", {27'd0, out_valid, out_kill, out_mask}, {27'd0, 1'b1, 1'b1, 4'b0000});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_bypass();
        t_four();
        t_two();
        t_one();
        t_reserved();
        t_and_kill();
        t_extremes();
        t_latency();
        t_stall();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule